// File: doc/BRIEF.md
# Three-wire EEPROM word reader

This block fetches one 16-bit word from a three-wire serial EEPROM. The host gives it a byte address and a one-cycle start pulse. The block then drives the chip-select, serial-clock and serial-out pins and samples the serial-in pin. When the word has arrived it returns the word with a one-cycle done pulse. Between those two events the block raises chip select, sends a fixed 13-bit read frame and clocks in 16 reply bits. It then drops every pin to release the device.

Every pin change is held for one phase. A phase is a fixed number of system clocks set by a parameter; the default is 100 us at 125 MHz. Only the read command is supported. Write, erase and write-enable commands are not.

The control is one state machine with these states:

- `ST_IDLE`: waiting for a start.
- `ST_SELECT`: chip-select setup.
- `ST_CMD_SET`, `ST_CMD_LOW`, `ST_CMD_HIGH`: the three phases of each command bit.
- `ST_RD_LOW`, `ST_RD_HIGH`: the two phases of each reply bit.
- `ST_RELEASE`: the final quiet phase.

Its transitions, each taken at the end of a phase unless stated otherwise:

- IDLE→SELECT when a start is accepted. This is the only transition not tied to a phase end.
- SELECT→CMD_SET.
- CMD_SET→CMD_LOW.
- CMD_LOW→CMD_HIGH.
- CMD_HIGH→CMD_SET for the next command bit, or CMD_HIGH→RD_LOW after the 13th bit.
- RD_LOW→RD_HIGH.
- RD_HIGH→RD_LOW for the next reply bit, or RD_HIGH→RELEASE after the 16th bit.
- RELEASE→IDLE, with done raised.

Top module: `mw_word_reader`

## Requirements
- R1: After a start is accepted, `mw_cs` goes high while `mw_sclk` and `mw_sout` stay low for exactly one phase before the first command bit appears.
- R2: The command frame is 13 bits sent MSB first. The first three bits sent are 1, 1, 0. The last ten are the word address, MSB first.
- R3: The word address in the frame is the byte address shifted right by one (`byte_addr[10:1]`), so its LSB is dropped.
- R4: Each command bit takes three phases. In the first, `mw_sout` takes the bit value with `mw_sclk` low. In the second, `mw_sclk` stays low. In the third, `mw_sclk` is high. `mw_sout` does not change across the three phases.
- R5: After the frame, 16 reply pulses follow, each one phase low and then one phase high. `mw_sin` is sampled at the last clock of each high phase. The first sampled bit becomes bit 15 of the result. During the reply `mw_sout` holds the last command bit.
- R6: After the 16th reply bit, `mw_cs`, `mw_sclk` and `mw_sout` are all low for one phase. The block then returns to idle.
- R7: Every phase lasts exactly `PHASE_CLKS` clocks. Done is high 73×`PHASE_CLKS` clock edges after the edge that accepted the start.
- R8: `done` is high for one clock. `rdata` takes the new word in that same clock and keeps it until the next read completes.
- R9: `busy` is high from the clock after an accepted start until the done clock, where it is low. A start that arrives while busy is ignored. A start in the done clock is accepted.
- R10: While the synchronous active-high reset is asserted, the block returns to idle. All three serial outputs, `busy`, `done` and `rdata` are low during reset and after it, until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle read request |
| byte_addr | input | ADDR_W (11) | Byte address of the requested word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W (16) | Word read from the device |
| mw_cs | output | 1 | Device chip select, active high |
| mw_sclk | output | 1 | Serial clock to the device |
| mw_sout | output | 1 | Serial data to the device |
| mw_sin | input | 1 | Serial data from the device |

## Verification
Once a start is accepted, each later clock falls at a known phase index: the clock count since acceptance divided by `PHASE_CLKS`. That index fixes the expected levels of chip select, serial clock and serial out. The reference model in the bench keeps that count as an integer. On every falling edge it compares all pins, `busy`, `done` and `rdata` against the values due for that count. Done and the new `rdata` are due exactly 73×`PHASE_CLKS` edges after acceptance, and `busy` is due high from the first edge after acceptance. A device model in the bench decodes the frame from the rising serial-clock edges and answers with a word computed from the address. The bench checks the decoded header and address at each done.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_CMD_SET,
        ST_CMD_LOW,
        ST_CMD_HIGH,
        ST_RD_LOW,
        ST_RD_HIGH,
        ST_RELEASE
    } mw_state_e;

    // start bit and read opcode, sent ahead of the word address
    localparam logic [2:0] MW_READ_HDR = 3'b110;

endpackage

// File: rtl/mw_phase_timer.sv
module mw_phase_timer #(
    parameter int PHASE_CLKS = 12500
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic phase_end
);
    localparam int CNT_W = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_CLKS - 1);

    logic [CNT_W-1:0] cnt_q;

    assign phase_end = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || phase_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R7: the count never runs past the phase length
    a_r7_phase_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/mw_cmd_shift.sv
module mw_cmd_shift #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [ADDR_W-1:0] byte_addr,
    output logic              bit_out
);
    import mw_pkg::*;

    localparam int WADDR_W = ADDR_W - 1;
    localparam int CMD_W   = 3 + WADDR_W;

    logic [CMD_W-1:0]   cmd_q;
    logic [WADDR_W-1:0] waddr;

    assign waddr   = WADDR_W'(byte_addr >> 1);
    assign bit_out = cmd_q[CMD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (load) begin
            cmd_q <= {MW_READ_HDR, waddr};
        end else if (shift) begin
            cmd_q <= {cmd_q[CMD_W-2:0], 1'b0};
        end
    end

    // R2: a fresh frame always starts with the header's first bit
    a_r2_frame_head: assert property (@(posedge clk) disable iff (rst)
        load |=> bit_out == MW_READ_HDR[2]);

endmodule

// File: rtl/mw_rx_shift.sv
module mw_rx_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic              sin,
    input  logic              capture,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] sreg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
            rdata  <= '0;
        end else begin
            if (sample) begin
                sreg_q <= {sreg_q[DATA_W-2:0], sin};
            end
            if (capture) begin
                rdata <= sreg_q;
            end
        end
    end

    // R8: the result only moves on a capture
    a_r8_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(rdata));

endmodule

// File: rtl/mw_word_reader.sv
module mw_word_reader #(
    parameter int PHASE_CLKS = 12500,
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] byte_addr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mw_cs,
    output logic              mw_sclk,
    output logic              mw_sout,
    input  logic              mw_sin
);
    import mw_pkg::*;

    localparam int CMD_W = 3 + ADDR_W - 1;
    localparam int MAX_N = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int BIT_W = $clog2(MAX_N);
    localparam logic [BIT_W-1:0] CMD_LAST = BIT_W'(CMD_W - 1);
    localparam logic [BIT_W-1:0] RD_LAST  = BIT_W'(DATA_W - 1);

    mw_state_e        state_q, state_d;
    logic [BIT_W-1:0] bit_q;
    logic             phase_end;
    logic             accept;
    logic             cmd_bit;
    logic             cmd_shift;
    logic             rx_sample;
    logic             finish;

    assign accept    = (state_q == ST_IDLE) && start;
    assign cmd_shift = (state_q == ST_CMD_HIGH) && phase_end && (bit_q != CMD_LAST);
    assign rx_sample = (state_q == ST_RD_HIGH) && phase_end;
    assign finish    = (state_q == ST_RELEASE) && phase_end;

    mw_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) i_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (state_q != ST_IDLE),
        .phase_end (phase_end)
    );

    mw_cmd_shift #(.ADDR_W(ADDR_W)) i_cmd (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .shift     (cmd_shift),
        .byte_addr (byte_addr),
        .bit_out   (cmd_bit)
    );

    mw_rx_shift #(.DATA_W(DATA_W)) i_rx (
        .clk     (clk),
        .rst     (rst),
        .sample  (rx_sample),
        .sin     (mw_sin),
        .capture (finish),
        .rdata   (rdata)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start)     state_d = ST_SELECT;
            ST_SELECT:   if (phase_end) state_d = ST_CMD_SET;
            ST_CMD_SET:  if (phase_end) state_d = ST_CMD_LOW;
            ST_CMD_LOW:  if (phase_end) state_d = ST_CMD_HIGH;
            ST_CMD_HIGH: if (phase_end) state_d = (bit_q == CMD_LAST) ? ST_RD_LOW : ST_CMD_SET;
            ST_RD_LOW:   if (phase_end) state_d = ST_RD_HIGH;
            ST_RD_HIGH:  if (phase_end) state_d = (bit_q == RD_LAST) ? ST_RELEASE : ST_RD_LOW;
            ST_RELEASE:  if (phase_end) state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // state register, bit counter and done pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= finish;
            if (state_q == ST_IDLE) begin
                bit_q <= '0;
            end else if (phase_end && ((state_q == ST_CMD_HIGH) || (state_q == ST_RD_HIGH))) begin
                if ((state_q == ST_CMD_HIGH && bit_q == CMD_LAST) ||
                    (state_q == ST_RD_HIGH && bit_q == RD_LAST)) begin
                    bit_q <= '0;
                end else begin
                    bit_q <= bit_q + 1'b1;
                end
            end
        end
    end

    // output decode
    always_comb begin
        mw_cs   = 1'b0;
        mw_sclk = 1'b0;
        mw_sout = 1'b0;
        busy    = 1'b1;
        unique case (state_q)
            ST_IDLE:     busy = 1'b0;
            ST_SELECT:   mw_cs = 1'b1;
            ST_CMD_SET,
            ST_CMD_LOW:  begin mw_cs = 1'b1; mw_sout = cmd_bit; end
            ST_CMD_HIGH: begin mw_cs = 1'b1; mw_sout = cmd_bit; mw_sclk = 1'b1; end
            ST_RD_LOW:   begin mw_cs = 1'b1; mw_sout = cmd_bit; end
            ST_RD_HIGH:  begin mw_cs = 1'b1; mw_sout = cmd_bit; mw_sclk = 1'b1; end
            ST_RELEASE:  ;
            default:     busy = 1'b0;
        endcase
    end

    // R1: the serial clock only rises with chip select held
    a_r1_cs_before_clock: assert property (@(posedge clk) disable iff (rst)
        $rose(mw_sclk) |-> mw_cs);

    // R4: serial out never moves on a rising serial clock
    a_r4_sout_stable_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(mw_sclk) |-> $stable(mw_sout));

    // R6: when chip select drops, the other pins are already low
    a_r6_release_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(mw_cs) |-> (!mw_sclk && !mw_sout));

    // R8: done lasts a single clock
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: busy holds until done and a start while busy changes nothing
    a_r9_busy_until_done: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || done));
    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

// File: tb/test_mw_word_reader.sv
module test_mw_word_reader;

    localparam int P     = 3;
    localparam int FRAME = 73 * P;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [10:0] byte_addr = '0;
    logic        busy, done, mw_cs, mw_sclk, mw_sout;
    logic        mw_sin = 1'b0;
    logic [15:0] rdata;

    always #4 clk = ~clk;

    mw_word_reader #(.PHASE_CLKS(P)) i_mw_word_reader (
        .clk(clk), .rst(rst), .start(start), .byte_addr(byte_addr),
        .busy(busy), .done(done), .rdata(rdata),
        .mw_cs(mw_cs), .mw_sclk(mw_sclk), .mw_sout(mw_sout), .mw_sin(mw_sin)
    );

    int n_chk = 0;
    int n_bad = 0;

    function automatic logic [15:0] word_of(input logic [9:0] w);
        return 16'(({6'b0, w} * 16'h9E37) ^ 16'h5AC3);
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: actual=%b expected=%b", tag, what, $time, act, exp);
        end
    endtask

    task automatic chk16(input logic [15:0] act, input logic [15:0] exp, input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: actual=%h expected=%h", tag, what, $time, act, exp);
        end
    endtask

    // device model: decodes the frame, answers on rising serial clock
    logic [12:0] ee_cmd = '0;
    logic [15:0] ee_word = '0;
    int          ee_bits = 0;
    int          ee_dn = 0;

    always @(posedge mw_sclk) begin
        if (mw_cs === 1'b1) begin
            if (ee_bits < 13) begin
                ee_cmd = {ee_cmd[11:0], mw_sout};
                ee_bits++;
                if (ee_bits == 13) ee_word = word_of(ee_cmd[9:0]);
            end else if (ee_dn < 16) begin
                mw_sin <= ee_word[15 - ee_dn];
                ee_dn++;
            end
        end
    end

    always @(negedge mw_cs) begin
        ee_bits = 0;
        ee_dn   = 0;
        mw_sin <= 1'b0;
    end

    // reference model: clock count since acceptance
    int          tick = -1;
    logic        done_exp = 1'b0;
    logic [15:0] rdata_exp = '0;
    logic [10:0] cur_addr = '0;
    logic        started = 1'b0;

    always @(posedge clk) begin
        started = 1'b1;
        if (rst) begin
            tick = -1;
            done_exp = 1'b0;
            rdata_exp = '0;
        end else begin
            done_exp = 1'b0;
            if (tick >= 0) begin
                tick++;
                if (tick == FRAME) begin
                    tick = -1;
                    done_exp = 1'b1;
                    rdata_exp = word_of(cur_addr[10:1]);
                end
            end else if (start) begin
                tick = 0;
                cur_addr = byte_addr;
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            logic [12:0] cmd;
            logic e_cs, e_sk, e_so;
            string tag;
            int ph;
            cmd  = {3'b110, cur_addr[10:1]};
            e_cs = 1'b0; e_sk = 1'b0; e_so = 1'b0;
            if (rst) tag = "R10";
            else tag = "R6";
            if (tick >= 0) begin
                ph = tick / P;
                if (ph == 0) begin
                    tag = "R1"; e_cs = 1'b1;
                end else if (ph <= 39) begin
                    tag = "R4"; e_cs = 1'b1;
                    e_so = cmd[12 - (ph - 1) / 3];
                    e_sk = ((ph - 1) % 3) == 2;
                end else if (ph <= 71) begin
                    tag = "R5"; e_cs = 1'b1;
                    e_so = cmd[0];
                    e_sk = ((ph - 40) % 2) == 1;
                end else begin
                    tag = "R6";
                end
            end
            chk(mw_cs, e_cs, tag, "chip select");
            chk(mw_sclk, e_sk, tag, "serial clock");
            chk(mw_sout, e_so, tag, "serial out");
            chk(busy, tick >= 0, rst ? "R10" : "R9", "busy");
            chk(done, done_exp, "R7/R8", "done");
            chk16(rdata, rdata_exp, "R8", "rdata");
            if (done_exp && !rst) begin
                chk16({13'b0, ee_cmd[12:10]}, 16'd6, "R2", "frame header");
                chk16({6'b0, ee_cmd[9:0]}, {6'b0, cur_addr[10:1]}, "R3", "frame word address");
                chk16(rdata, word_of(cur_addr[10:1]), "R5", "word bit order");
            end
        end
    end

    task automatic pulse_start(input logic [10:0] a);
        @(negedge clk);
        byte_addr = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (done !== 1'b1) @(negedge clk);
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R10 reset state is compared on every cycle above
        repeat (3) @(negedge clk);

        pulse_start(11'h000);
        wait_done();
        pulse_start(11'h7FF);          // highest address, odd byte
        wait_done();
        pulse_start(11'h2A5);
        // R9: start while busy with another address is ignored
        repeat (50) @(negedge clk);
        pulse_start(11'h154);
        wait_done();
        // R9: start in the done cycle is accepted
        byte_addr = 11'h154;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (5) @(negedge clk);
        // R8: rdata holds while idle and through the next transfer
        pulse_start(11'h0B3);
        repeat (100) @(negedge clk);
        // R10: reset in the middle of a transfer
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        pulse_start(11'h3C8);
        wait_done();
        repeat (5) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule